// File: doc/BRIEF.md
# Level-Sensitive Scan Latch Chain

This block is a chain of `N` storage cells. Each cell is a pair of level-sensitive latches rather than an edge-triggered flip-flop. The first latch of a cell (the functional latch) drives the cell's bit on the parallel output bus. It is open to the functional data input while the capture clock is high. It is open to the scan input while the master shift clock is high. The second latch (the shift latch) copies the functional latch while the slave shift clock is high. Each shift latch feeds the scan input of the next cell.

In normal operation both shift clocks stay low, and the capture clock strobes data from the surrounding logic into the functional latches. In test operation the capture clock stays low. Alternating master and slave pulses then move a pattern serially from `scan_in`, through every cell, to `scan_out`. One master pulse followed by one slave pulse advances the chain by one bit.

To read a response, the tester does the following:
1. Pulse the capture clock once.
2. Pulse the slave clock once, so the captured values reach the shift latches.
3. Unload the chain with `N` master/slave pairs.

A flag reports any cycle in which two or more of the three clocks are high together. While that flag is high, the latch contents are not guaranteed.

Top module: `lssd_chain`

## Requirements
- R1: While `rst` is high, every functional and shift latch clears to 0, so `func_q` reads all zeros and `scan_out` reads 0.
- R2: While `cap_clk` is high and both shift clocks are low, `func_q` follows `func_d` bit for bit.
- R3: While all three clocks are low, changes on `func_d` and `scan_in` leave `func_q` and `scan_out` unchanged.
- R4: A pulse of `cap_clk` alone leaves every shift latch unchanged, so `scan_out` keeps its value.
- R5: A pulse of `shm_clk` alone loads `func_q[0]` from `scan_in` and loads `func_q[i]` from the shift latch of cell `i-1` for every i ≥ 1.
- R6: A pulse of `shm_clk` alone does not change `scan_out`. A following pulse of `shs_clk` copies each functional latch into its shift latch, so `scan_out` then equals `func_q[N-1]`.
- R7: Each master/slave pair advances the chain by one bit toward higher indices. Bits presented on `scan_in` as p[N-1] first and p[0] last leave `func_q[i] = p[i]` after N pairs. `scan_out` presents the bit held in cell N-1-k after k further pairs.
- R8: `ovl_err` is 1 exactly when two or more of `cap_clk`, `shm_clk` and `shs_clk` are high at once. It is 0 whenever at most one of them is high.
- R9: A response captured with `cap_clk` and then transferred with one `shs_clk` pulse is unloaded by N further pairs as bits `func_d[N-1]` down to `func_d[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst | input | 1 | Asynchronous active-high clear of all latches |
| cap_clk | input | 1 | System capture clock; opens functional latches to `func_d` |
| shm_clk | input | 1 | Master shift clock; opens functional latches to the scan path |
| shs_clk | input | 1 | Slave shift clock; opens shift latches to their functional latch |
| func_d | input | N | Parallel functional data into the cells |
| func_q | output | N | Parallel functional latch outputs |
| scan_in | input | 1 | Serial input to cell 0 |
| scan_out | output | 1 | Shift latch of cell N-1 |
| ovl_err | output | 1 | Two or more clocks high at the same time |

## Verification
The assertions are evaluated at every falling clock edge. They check three things:
- a falling capture clock leaves each functional latch equal to its data bit;
- a falling master clock leaves each functional latch equal to the previous cell's shift latch, and cell 0 equal to `scan_in`;
- a falling slave clock leaves each shift latch equal to its functional latch.

At each falling edge they also check that the overlap flag agrees with the other clocks' levels.

Some behaviours only the bench scenarios can show. These are the end-to-end bit ordering over a full load and unload, the capture-then-unload flow, and the holding of state when inputs change while the clocks are idle. The bench also shows that an isolated capture or master pulse leaves `scan_out` alone.

// File: rtl/lssd_pkg.sv
package lssd_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE     = 3'd0,
    MODE_CAPTURE  = 3'd1,
    MODE_SHIFT_M  = 3'd2,
    MODE_SHIFT_S  = 3'd3,
    MODE_CONFLICT = 3'd4
  } clk_mode_e;

  function automatic clk_mode_e decode_mode(input logic cap, input logic shm, input logic shs);
    logic [1:0] n_hi;
    n_hi = 2'(cap) + 2'(shm) + 2'(shs);
    if (n_hi > 2'd1)  return MODE_CONFLICT;
    else if (cap)     return MODE_CAPTURE;
    else if (shm)     return MODE_SHIFT_M;
    else if (shs)     return MODE_SHIFT_S;
    else              return MODE_IDLE;
  endfunction

endpackage

// File: rtl/lssd_clk_monitor.sv
module lssd_clk_monitor
  import lssd_pkg::*;
(
  input  logic      cap_clk,
  input  logic      shm_clk,
  input  logic      shs_clk,
  output clk_mode_e mode,
  output logic      conflict
);

  always_comb begin
    mode     = decode_mode(cap_clk, shm_clk, shs_clk);
    conflict = (mode == MODE_CONFLICT);
  end

endmodule

// File: rtl/lssd_cell.sv
module lssd_cell (
  input  logic rst,
  input  logic cap_clk,
  input  logic shm_clk,
  input  logic shs_clk,
  input  logic d,
  input  logic si,
  output logic l1,
  output logic l2
);

  // Functional latch: capture path has priority if clocks collide.
  always_latch begin
    if (rst)          l1 <= 1'b0;
    else if (cap_clk) l1 <= d;
    else if (shm_clk) l1 <= si;
  end

  // Shift latch: transparent to the functional latch while slave clock high.
  always_latch begin
    if (rst)          l2 <= 1'b0;
    else if (shs_clk) l2 <= l1;
  end

  AST_CAPTURE_FOLLOWS: assert property (@(negedge cap_clk) disable iff (rst)
    (!shm_clk && !shs_clk) |-> (l1 == d)); // R2

  AST_SLAVE_COPIES: assert property (@(negedge shs_clk) disable iff (rst)
    (!shm_clk && !cap_clk) |-> (l2 == l1)); // R6

endmodule

// File: rtl/lssd_chain.sv
module lssd_chain
  import lssd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         rst,
  input  logic         cap_clk,
  input  logic         shm_clk,
  input  logic         shs_clk,
  input  logic [N-1:0] func_d,
  output logic [N-1:0] func_q,
  input  logic         scan_in,
  output logic         scan_out,
  output logic         ovl_err
);

  localparam int LAST = N - 1;

  logic [N-1:0] shift_q;
  logic [N-1:0] scan_link;
  clk_mode_e    mode;

  lssd_clk_monitor u_mon (
    .cap_clk  (cap_clk),
    .shm_clk  (shm_clk),
    .shs_clk  (shs_clk),
    .mode     (mode),
    .conflict (ovl_err)
  );

  assign scan_link[0] = scan_in;

  for (genvar i = 0; i < N; i++) begin : g_cell
    if (i > 0) begin : g_link
      assign scan_link[i] = shift_q[i-1];
    end
    lssd_cell u_cell (
      .rst     (rst),
      .cap_clk (cap_clk),
      .shm_clk (shm_clk),
      .shs_clk (shs_clk),
      .d       (func_d[i]),
      .si      (scan_link[i]),
      .l1      (func_q[i]),
      .l2      (shift_q[i])
    );
    if (i > 0) begin : g_chk
      AST_MASTER_LINK: assert property (@(negedge shm_clk) disable iff (rst)
        (!cap_clk && !shs_clk) |-> (func_q[i] == shift_q[i-1])); // R5
    end
  end

  assign scan_out = shift_q[LAST];

  AST_MASTER_HEAD: assert property (@(negedge shm_clk) disable iff (rst)
    (!cap_clk && !shs_clk) |-> (func_q[0] == scan_in)); // R5

  AST_OVERLAP_SEEN: assert property (@(negedge cap_clk) disable iff (rst)
    (shm_clk || shs_clk) |-> ovl_err); // R8

  AST_OVERLAP_CLEAR: assert property (@(negedge shm_clk) disable iff (rst)
    (!cap_clk && !shs_clk) |-> !ovl_err); // R8

  AST_RESET_CLEAR: assert property (@(negedge shs_clk) disable iff (!rst)
    (scan_out == 1'b0)); // R1

  logic unused_mode;
  assign unused_mode = ^mode;

endmodule

// File: tb/lssd_chain_tb.sv
module lssd_chain_tb;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic         cap_clk, shm_clk, shs_clk;
  logic [N-1:0] func_d;
  logic [N-1:0] func_q;
  logic         scan_in;
  logic         scan_out;
  logic         ovl_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic exp_q[$];
  string exp_tag[$];
  event  sample_ev;

  always #2 clk = ~clk;

  lssd_chain #(.N(N)) u_dut (
    .rst(rst), .cap_clk(cap_clk), .shm_clk(shm_clk), .shs_clk(shs_clk),
    .func_d(func_d), .func_q(func_q), .scan_in(scan_in),
    .scan_out(scan_out), .ovl_err(ovl_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_cap();
    @(negedge clk); cap_clk = 1'b1;
    repeat (2) @(negedge clk);
    cap_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_shm();
    @(negedge clk); shm_clk = 1'b1;
    repeat (2) @(negedge clk);
    shm_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_shs();
    @(negedge clk); shs_clk = 1'b1;
    repeat (2) @(negedge clk);
    shs_clk = 1'b0;
    @(negedge clk);
  endtask

  task automatic load(input logic [N-1:0] p);
    for (int k = 0; k < N; k++) begin
      scan_in = p[N-1-k];
      pulse_shm();
      pulse_shs();
    end
    scan_in = 1'b0;
  endtask

  // Driver side of the scoreboard: push expected serial bits, then shift.
  task automatic unload(input logic [N-1:0] exp, input string req);
    for (int k = 0; k < N; k++) begin
      exp_q.push_back(exp[N-1-k]);
      exp_tag.push_back(req);
      -> sample_ev;
      @(negedge clk);
      pulse_shm();
      pulse_shs();
    end
  endtask

  // Monitor side of the scoreboard.
  initial begin
    forever begin
      @(sample_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard", 64'(scan_out), 64'hx);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        check(scan_out === e, t, 64'(scan_out), 64'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] pat_a, pat_b, resp;
    logic         so_before;
    rst = 1'b1; cap_clk = 1'b0; shm_clk = 1'b0; shs_clk = 1'b0;
    func_d = '1; scan_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset clears both latches of every cell
    check(func_q === '0, "R1 func_q", 64'(func_q), 64'd0);
    check(scan_out === 1'b0, "R1 scan_out", 64'(scan_out), 64'd0);
    check(ovl_err === 1'b0, "R8 idle flag", 64'(ovl_err), 64'd0);
    rst = 1'b0; scan_in = 1'b0;
    repeat (2) @(negedge clk);

    // R7: full serial load gives parallel image
    pat_a = 8'b1011_0010;
    load(pat_a);
    check(func_q === pat_a, "R7 load image", 64'(func_q), 64'(pat_a));
    check(scan_out === pat_a[N-1], "R6 scan_out after load", 64'(scan_out), 64'(pat_a[N-1]));

    // R3: idle clocks hold state against input changes
    func_d = 8'h5A; scan_in = 1'b1;
    repeat (4) @(negedge clk);
    check(func_q === pat_a, "R3 hold func_q", 64'(func_q), 64'(pat_a));
    check(scan_out === pat_a[N-1], "R3 hold scan_out", 64'(scan_out), 64'(pat_a[N-1]));

    // R5/R6: single master pulse, then single slave pulse
    scan_in = 1'b1;
    pulse_shm();
    check(func_q === {pat_a[N-2:0], 1'b1}, "R5 master shift", 64'(func_q), 64'({pat_a[N-2:0], 1'b1}));
    check(scan_out === pat_a[N-1], "R6 master alone keeps scan_out", 64'(scan_out), 64'(pat_a[N-1]));
    pulse_shs();
    check(scan_out === pat_a[N-2], "R6 slave copies", 64'(scan_out), 64'(pat_a[N-2]));
    scan_in = 1'b0;

    // R7: unload a second pattern, check serial order
    pat_b = 8'b0110_1101;
    load(pat_b);
    unload(pat_b, "R7 unload order");
    check(func_q === '0, "R7 zeros followed", 64'(func_q), 64'd0);

    // R2/R4: capture without disturbing shift latches
    pat_a = 8'b1110_0001;
    load(pat_a);
    so_before = scan_out;
    resp = 8'b0011_1010;
    func_d = resp;
    @(negedge clk); cap_clk = 1'b1;
    repeat (2) @(negedge clk);
    check(func_q === resp, "R2 follow while cap high", 64'(func_q), 64'(resp));
    func_d = 8'hC5;
    @(negedge clk);
    check(func_q === 8'hC5, "R2 transparent", 64'(func_q), 64'hC5);
    func_d = resp;
    @(negedge clk);
    cap_clk = 1'b0;
    @(negedge clk);
    func_d = 8'hFF;
    @(negedge clk);
    check(func_q === resp, "R3 hold after capture", 64'(func_q), 64'(resp));
    check(scan_out === so_before, "R4 capture keeps shift latch", 64'(scan_out), 64'(so_before));

    // R9: transfer and unload the captured response
    pulse_shs();
    unload(resp, "R9 capture unload");

    // R8: overlap detection for each pair and all three
    @(negedge clk); shm_clk = 1'b1; shs_clk = 1'b1; @(negedge clk);
    check(ovl_err === 1'b1, "R8 master+slave", 64'(ovl_err), 64'd1);
    shs_clk = 1'b0; @(negedge clk);
    check(ovl_err === 1'b0, "R8 master only", 64'(ovl_err), 64'd0);
    cap_clk = 1'b1; @(negedge clk);
    check(ovl_err === 1'b1, "R8 cap+master", 64'(ovl_err), 64'd1);
    shm_clk = 1'b0; shs_clk = 1'b1; @(negedge clk);
    check(ovl_err === 1'b1, "R8 cap+slave", 64'(ovl_err), 64'd1);
    shm_clk = 1'b1; @(negedge clk);
    check(ovl_err === 1'b1, "R8 all three", 64'(ovl_err), 64'd1);
    cap_clk = 1'b0; shm_clk = 1'b0; shs_clk = 1'b0; @(negedge clk);
    check(ovl_err === 1'b0, "R8 released", 64'(ovl_err), 64'd0);

    // R1: reset after an overlap restores a known state
    rst = 1'b1; @(negedge clk);
    check(func_q === '0, "R1 re-reset func_q", 64'(func_q), 64'd0);
    check(scan_out === 1'b0, "R1 re-reset scan_out", 64'(scan_out), 64'd0);
    rst = 1'b0; @(negedge clk);

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) check(1'b0, "scoreboard drain", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule